// File: doc/BRIEF.md
# Oscillator Trim Search Controller

This block tunes an on-chip oscillator toward a requested meter count. It drives two trim codes: a coarse divider code and a fine calibration code. For each pair of codes it asks an external frequency meter for one measurement. It compares the count that comes back with the target and moves the active code by one step. The oscillator's count is assumed to rise with both codes.

The search has two stages. First the coarse code walks one step at a time until the error changes sign. The controller then keeps whichever of the two codes on either side of the target gave the smaller error. It repeats the same walk on the fine code, starting from that point. When the fine stage also sees a sign change, the chosen pair is applied and measured one last time, and that count is reported.

A zero count from the meter aborts the search with a failure. So does a code that would step out of its range. The target count for a frequency in MHz is round(MHz × 1024 / 26), and the user supplies it on `target_i`.

Top module: `osc_trim_search`

## Requirements
- R1: After reset, busy_o, done_o, fail_o and meas_req_o are 0, final_cnt_o is 0, the coarse code equals 2^(DIV_W-1) and the fine code equals 2^(CALI_W-1).
- R2: A start_i pulse loads both codes to half of their range, clears done_o and fail_o, and raises meas_req_o.
- R3: After a measurement with no sign change, the active code (coarse in the first stage, fine in the second) steps by +1 when the count is below target_i and by -1 when it is above. The other code is left unchanged.
- R4: On the first measurement no sign comparison is made. When the sign of (target − count) differs from the sign at the previous measurement, the point with the strictly smaller absolute error is kept, and on a tie the current point is kept. The first such change moves the search to the fine code, which then steps from the kept point in the direction of the kept point's error.
- R5: The second sign change ends the walk. The kept codes are driven, one more measurement is made, and its count appears on final_cnt_o with done_o=1 and fail_o=0.
- R6: A measured count of zero ends the search at once with done_o=1, fail_o=1 and final_cnt_o=0. No further request is issued.
- R7: If a step would move the active code below 0 or above its maximum (2^W − 1), the search ends with done_o=1 and fail_o=1. The code stays at its last in-range value.
- R8: A count exactly equal to target_i ends the walk as a match. That pair is measured once more and reported as in R5.
- R9: meas_req_o stays high from the start of a request until meas_done_i is seen. Each meas_done_i pulse completes exactly one measurement.
- R10: done_o and fail_o hold their values until the next start_i. fail_o is never 1 without done_o. busy_o is high only while a search runs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse for a new search |
| target_i | input | CNT_W | Target meter count, held during the search |
| meas_req_o | output | 1 | Measurement request to the meter |
| meas_done_i | input | 1 | One-cycle pulse: meter result valid |
| meas_cnt_i | input | CNT_W | Meter count, valid with meas_done_i |
| div_code_o | output | DIV_W | Coarse divider trim code |
| cali_code_o | output | CALI_W | Fine calibration trim code |
| busy_o | output | 1 | Search in progress |
| done_o | output | 1 | Search finished |
| fail_o | output | 1 | Search finished with failure |
| final_cnt_o | output | CNT_W | Count from the final measurement |

## Verification
The assertions check several properties on every cycle. The request is held until the meter answers. No code ever moves by more than one step between cycles while a search runs. Failure is always flagged together with done, and no request follows a failure. Done stays high until the next start. Which code pair the search settles on, the tie rule, the stage switch, the range and zero failures, and the number of meter requests can only be shown by the bench's scenarios. The bench drives a monotonic oscillator model and compares the results with a reference walk computed from the requirements.

// File: rtl/osc_trim_pkg.sv
package osc_trim_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MEAS,
    ST_EVAL,
    ST_FMEAS,
    ST_DONE
  } trim_st_e;

  typedef enum logic [1:0] {
    SG_ZERO = 2'd0,
    SG_POS  = 2'd1,
    SG_NEG  = 2'd2
  } err_sg_e;
endpackage

// File: rtl/trim_err_cmp.sv
module trim_err_cmp
  import osc_trim_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] target_i,
  input  logic [CNT_W-1:0] cnt_i,
  output err_sg_e          sg_o,
  output logic [CNT_W-1:0] abs_o
);
  logic [CNT_W:0] diff;

  always_comb begin
    diff = {1'b0, target_i} - {1'b0, cnt_i};
    if (diff == '0) sg_o = SG_ZERO;
    else if (diff[CNT_W]) sg_o = SG_NEG;
    else sg_o = SG_POS;
    abs_o = diff[CNT_W] ? CNT_W'(-diff) : diff[CNT_W-1:0];
  end
endmodule

// File: rtl/trim_code_step.sv
module trim_code_step
  import osc_trim_pkg::*;
#(
  parameter int W = 5
) (
  input  logic [W-1:0] code_i,
  input  err_sg_e      sg_i,
  output logic [W-1:0] code_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] CODE_MAX = {W{1'b1}};

  always_comb begin
    code_o = code_i;
    ovf_o  = 1'b0;
    unique case (sg_i)
      SG_POS: begin
        if (code_i == CODE_MAX) ovf_o = 1'b1;
        else code_o = code_i + 1'b1;
      end
      SG_NEG: begin
        if (code_i == '0) ovf_o = 1'b1;
        else code_o = code_i - 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/osc_trim_search.sv
module osc_trim_search
  import osc_trim_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DIV_W  = 5,
  parameter int CALI_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [CNT_W-1:0]  target_i,
  output logic              meas_req_o,
  input  logic              meas_done_i,
  input  logic [CNT_W-1:0]  meas_cnt_i,
  output logic [DIV_W-1:0]  div_code_o,
  output logic [CALI_W-1:0] cali_code_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              fail_o,
  output logic [CNT_W-1:0]  final_cnt_o
);
  localparam logic [DIV_W-1:0]  DIV_MID  = DIV_W'(1) << (DIV_W - 1);
  localparam logic [CALI_W-1:0] CALI_MID = CALI_W'(1) << (CALI_W - 1);

  trim_st_e          st_q, st_d;
  logic [DIV_W-1:0]  div_q, div_d, pdiv_q, pdiv_d;
  logic [CALI_W-1:0] cali_q, cali_d, pcali_q, pcali_d;
  logic              fine_q, fine_d, pv_q, pv_d;
  err_sg_e           psg_q, psg_d;
  logic [CNT_W-1:0]  pabs_q, pabs_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, fcnt_q, fcnt_d;
  logic              done_q, done_d, fail_q, fail_d;

  err_sg_e           cur_sg, sel_sg;
  logic [CNT_W-1:0]  cur_abs, sel_abs;
  logic [DIV_W-1:0]  sel_div, step_div;
  logic [CALI_W-1:0] sel_cali, step_cali;
  logic              ovf_div, ovf_cali, chg, take_prev;

  trim_err_cmp #(.CNT_W(CNT_W)) u_cmp (
    .target_i(target_i),
    .cnt_i   (cnt_q),
    .sg_o    (cur_sg),
    .abs_o   (cur_abs)
  );

  // sign change against the previous point; ties keep the current point
  always_comb begin
    chg       = pv_q && (cur_sg != psg_q);
    take_prev = chg && (pabs_q < cur_abs);
    sel_div   = take_prev ? pdiv_q  : div_q;
    sel_cali  = take_prev ? pcali_q : cali_q;
    sel_sg    = take_prev ? psg_q   : cur_sg;
    sel_abs   = take_prev ? pabs_q  : cur_abs;
  end

  trim_code_step #(.W(DIV_W)) u_step_div (
    .code_i(sel_div),
    .sg_i  (sel_sg),
    .code_o(step_div),
    .ovf_o (ovf_div)
  );

  trim_code_step #(.W(CALI_W)) u_step_cali (
    .code_i(sel_cali),
    .sg_i  (sel_sg),
    .code_o(step_cali),
    .ovf_o (ovf_cali)
  );

  always_comb begin
    st_d    = st_q;
    div_d   = div_q;
    cali_d  = cali_q;
    pdiv_d  = pdiv_q;
    pcali_d = pcali_q;
    fine_d  = fine_q;
    pv_d    = pv_q;
    psg_d   = psg_q;
    pabs_d  = pabs_q;
    cnt_d   = cnt_q;
    fcnt_d  = fcnt_q;
    done_d  = done_q;
    fail_d  = fail_q;
    unique case (st_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          st_d   = ST_MEAS;
          div_d  = DIV_MID;
          cali_d = CALI_MID;
          fine_d = 1'b0;
          pv_d   = 1'b0;
          done_d = 1'b0;
          fail_d = 1'b0;
          fcnt_d = '0;
        end
      end
      ST_MEAS: begin
        if (meas_done_i) begin
          cnt_d = meas_cnt_i;
          st_d  = ST_EVAL;
        end
      end
      ST_EVAL: begin
        if (cnt_q == '0) begin
          st_d   = ST_DONE;
          done_d = 1'b1;
          fail_d = 1'b1;
        end else if (cur_sg == SG_ZERO) begin
          st_d = ST_FMEAS;
        end else if (chg && fine_q) begin
          div_d  = sel_div;
          cali_d = sel_cali;
          st_d   = ST_FMEAS;
        end else begin
          fine_d  = fine_q | chg;
          pv_d    = 1'b1;
          pdiv_d  = sel_div;
          pcali_d = sel_cali;
          psg_d   = sel_sg;
          pabs_d  = sel_abs;
          div_d   = sel_div;
          cali_d  = sel_cali;
          if (fine_d) begin
            if (ovf_cali) begin
              st_d   = ST_DONE;
              done_d = 1'b1;
              fail_d = 1'b1;
            end else begin
              cali_d = step_cali;
              st_d   = ST_MEAS;
            end
          end else begin
            if (ovf_div) begin
              st_d   = ST_DONE;
              done_d = 1'b1;
              fail_d = 1'b1;
            end else begin
              div_d = step_div;
              st_d  = ST_MEAS;
            end
          end
        end
      end
      ST_FMEAS: begin
        if (meas_done_i) begin
          fcnt_d = meas_cnt_i;
          done_d = 1'b1;
          st_d   = ST_DONE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      div_q   <= DIV_MID;
      cali_q  <= CALI_MID;
      pdiv_q  <= DIV_MID;
      pcali_q <= CALI_MID;
      fine_q  <= 1'b0;
      pv_q    <= 1'b0;
      psg_q   <= SG_ZERO;
      pabs_q  <= '0;
      cnt_q   <= '0;
      fcnt_q  <= '0;
      done_q  <= 1'b0;
      fail_q  <= 1'b0;
    end else begin
      st_q    <= st_d;
      div_q   <= div_d;
      cali_q  <= cali_d;
      pdiv_q  <= pdiv_d;
      pcali_q <= pcali_d;
      fine_q  <= fine_d;
      pv_q    <= pv_d;
      psg_q   <= psg_d;
      pabs_q  <= pabs_d;
      cnt_q   <= cnt_d;
      fcnt_q  <= fcnt_d;
      done_q  <= done_d;
      fail_q  <= fail_d;
    end
  end

  assign meas_req_o  = (st_q == ST_MEAS) || (st_q == ST_FMEAS);
  assign busy_o      = (st_q != ST_IDLE) && (st_q != ST_DONE);
  assign div_code_o  = div_q;
  assign cali_code_o = cali_q;
  assign done_o      = done_q;
  assign fail_o      = fail_q;
  assign final_cnt_o = fcnt_q;
endmodule

// File: rtl/osc_trim_search_chk.sv
module osc_trim_search_chk #(
  parameter int DIV_W  = 5,
  parameter int CALI_W = 6
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              start_i,
  input logic              meas_req_o,
  input logic              meas_done_i,
  input logic [DIV_W-1:0]  div_code_o,
  input logic [CALI_W-1:0] cali_code_o,
  input logic              busy_o,
  input logic              done_o,
  input logic              fail_o
);
  // R9
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_req_o && !meas_done_i |=> meas_req_o);

  // R3
  div_unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> (div_code_o == $past(div_code_o)) ||
      (div_code_o == $past(div_code_o) + 1'b1) || (div_code_o == $past(div_code_o) - 1'b1));

  // R3
  cali_unit_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && $past(busy_o) |-> (cali_code_o == $past(cali_code_o)) ||
      (cali_code_o == $past(cali_code_o) + 1'b1) || (cali_code_o == $past(cali_code_o) - 1'b1));

  // R10
  fail_needs_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> done_o && !busy_o);

  // R6
  no_req_after_fail_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !meas_req_o);

  // R10
  done_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o && !start_i |=> done_o && $stable(fail_o));
endmodule

bind osc_trim_search osc_trim_search_chk #(.DIV_W(DIV_W), .CALI_W(CALI_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .start_i    (start_i),
  .meas_req_o (meas_req_o),
  .meas_done_i(meas_done_i),
  .div_code_o (div_code_o),
  .cali_code_o(cali_code_o),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .fail_o     (fail_o)
);

// File: tb/tb_osc_trim_search.sv
module tb_osc_trim_search;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W  = 16;
  localparam int DIV_W  = 5;
  localparam int CALI_W = 6;
  localparam int DIV_MAX  = 1 << DIV_W;
  localparam int CALI_MAX = 1 << CALI_W;
  localparam int LAT = 3;
  localparam int VEC_N = 6;
  localparam int V_SCALE [VEC_N] = '{400, 50, 50, 200, 120, 300};
  localparam int V_MHZ   [VEC_N] = '{250, 25, 30, 80, 40, 150};

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [CNT_W-1:0] target_i = '0;
  logic meas_req_o, meas_done_i;
  logic [CNT_W-1:0] meas_cnt_i;
  logic [DIV_W-1:0] div_code_o;
  logic [CALI_W-1:0] cali_code_o;
  logic busy_o, done_o, fail_o;
  logic [CNT_W-1:0] final_cnt_o;

  int n_chk = 0, n_fail = 0;
  int scale = 50;
  bit zero_mode = 1'b0;
  int nreq = 0;
  int lat_cnt = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  osc_trim_search #(.CNT_W(CNT_W), .DIV_W(DIV_W), .CALI_W(CALI_W)) dut (.*);

  function automatic int osc_f(int d, int c);
    if (zero_mode) return 0;
    return ((d + 4) * (c + 32) * scale) / 64;
  endfunction

  // behavioural meter: fixed latency, one-cycle done pulse
  initial begin
    meas_done_i = 1'b0;
    meas_cnt_i  = '0;
  end
  always @(posedge clk_i) begin
    if (meas_done_i) meas_done_i <= 1'b0;
    else if (lat_cnt > 0) begin
      lat_cnt <= lat_cnt - 1;
      if (lat_cnt == 1) begin
        meas_done_i <= 1'b1;
        meas_cnt_i  <= CNT_W'(osc_f(int'(div_code_o), int'(cali_code_o)));
      end
    end else if (meas_req_o && rst_ni) begin
      lat_cnt <= LAT;
      nreq    <= nreq + 1;
    end
  end

  function automatic int sgn(int v);
    return (v > 0) ? 1 : ((v < 0) ? -1 : 0);
  endfunction
  function automatic int iabs(int v);
    return (v < 0) ? -v : v;
  endfunction

  // reference walk built from the requirements
  task automatic ref_run(input int tgt, output int d, output int c, output int fc,
                         output bit fl, output int nr);
    int f, e, sg, pd, pc, pf, psg, nx;
    bit pv, fine, stop;
    d = DIV_MAX/2; c = CALI_MAX/2; fl = 0; nr = 0; fc = 0;
    pv = 0; fine = 0; stop = 0; pd = 0; pc = 0; pf = 0; psg = 0;
    for (int it = 0; it < 400 && !stop; it++) begin
      f = osc_f(d, c); nr++;
      if (f == 0) begin fl = 1; return; end
      e = tgt - f; sg = sgn(e);
      if (sg == 0) begin stop = 1; break; end
      if (pv && sg != psg) begin
        if (iabs(tgt - pf) < iabs(e)) begin d = pd; c = pc; f = pf; sg = psg; end
        if (fine) begin stop = 1; break; end
        fine = 1;
      end
      pd = d; pc = c; pf = f; psg = sg; pv = 1;
      if (!fine) begin
        nx = d + sg;
        if (nx < 0 || nx >= DIV_MAX) begin fl = 1; return; end
        d = nx;
      end else begin
        nx = c + sg;
        if (nx < 0 || nx >= CALI_MAX) begin fl = 1; return; end
        c = nx;
      end
    end
    fc = osc_f(d, c); nr++;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_search(input int tgt);
    @(negedge clk_i);
    target_i = CNT_W'(tgt);
    nreq = 0;
    start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk_i);
    repeat (3) @(negedge clk_i);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    int ed, ec, efc, enr;
    bit efl;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 busy", busy_o, 0);
    chk("R1 done", done_o, 0);
    chk("R1 fail", fail_o, 0);
    chk("R1 req", meas_req_o, 0);
    chk("R1 div", div_code_o, DIV_MAX/2);
    chk("R1 cali", cali_code_o, CALI_MAX/2);
    chk("R1 final", final_cnt_o, 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);

    // vector table: R4 R5 general walks
    for (int v = 0; v < VEC_N; v++) begin
      int tgt;
      scale = V_SCALE[v];
      tgt = (V_MHZ[v] * 1024 + 13) / 26;
      ref_run(tgt, ed, ec, efc, efl, enr);
      run_search(tgt);
      chk("R4 div", div_code_o, ed);
      chk("R4 cali", cali_code_o, ec);
      chk("R5 final", final_cnt_o, efc);
      chk("R5 fail", fail_o, efl);
      chk("R9 requests", nreq, enr);
    end

    // R5 hand-computed: 250 MHz, scale 400 -> div 21, cali 31, count 9843
    scale = 400;
    run_search((250 * 1024 + 13) / 26);
    chk("R5 hand div", div_code_o, 21);
    chk("R5 hand cali", cali_code_o, 31);
    chk("R5 hand final", final_cnt_o, 9843);
    chk("R5 hand done", done_o, 1);

    // R2 R3: upward step on coarse code, fine untouched
    scale = 50;
    @(negedge clk_i);
    target_i = 16'd1200; nreq = 0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    chk("R2 req", meas_req_o, 1);
    chk("R2 done cleared", done_o, 0);
    chk("R2 div", div_code_o, DIV_MAX/2);
    for (int i = 0; i < 100 && nreq < 2; i++) @(negedge clk_i);
    chk("R3 div up", div_code_o, DIV_MAX/2 + 1);
    chk("R3 cali held", cali_code_o, CALI_MAX/2);
    for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk_i);

    // R3 downward step
    @(negedge clk_i);
    target_i = 16'd800; nreq = 0; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    for (int i = 0; i < 100 && nreq < 2; i++) @(negedge clk_i);
    chk("R3 div down", div_code_o, DIV_MAX/2 - 1);
    chk("R3 cali held down", cali_code_o, CALI_MAX/2);
    for (int i = 0; i < 20000 && !done_o; i++) @(negedge clk_i);

    // R8 exact match: f(16,32) = 20*scale = 1000
    run_search(1000);
    chk("R8 div", div_code_o, DIV_MAX/2);
    chk("R8 cali", cali_code_o, CALI_MAX/2);
    chk("R8 final", final_cnt_o, 1000);
    chk("R8 fail", fail_o, 0);
    chk("R8 requests", nreq, 2);

    // R7 range: unreachable high target, div walks to 31 then fails
    run_search(60000);
    chk("R7 fail", fail_o, 1);
    chk("R7 done", done_o, 1);
    chk("R7 div", div_code_o, DIV_MAX - 1);
    chk("R7 requests", nreq, DIV_MAX/2);

    // R6 zero count
    zero_mode = 1'b1;
    run_search(1000);
    chk("R6 fail", fail_o, 1);
    chk("R6 final", final_cnt_o, 0);
    chk("R6 requests", nreq, 1);
    chk("R6 req low", meas_req_o, 0);
    // R10 flags hold with no start
    repeat (20) @(negedge clk_i);
    chk("R10 done held", done_o, 1);
    chk("R10 fail held", fail_o, 1);
    chk("R10 busy", busy_o, 0);
    zero_mode = 1'b0;

    // R10 new start clears fail
    run_search(1000);
    chk("R10 fail cleared", fail_o, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule